// File: doc/BRIEF.md
# Peripheral Register Window Decoder with Bus-Fault Arbitration

This block sits between a CPU bus and a 64 KiB peripheral register window. For each access it works out which byte locations are touched and whether they are real registers, silent holes or faulting holes. The access then ends in exactly one of three ways: a transfer acknowledge, a bus-error response, or an address-error response. Faults are judged one byte at a time. A word access faults only when both of its bytes would fault if accessed alone. A long access is treated as two words and faults when either of those words faults.

The block holds a single configuration word. Its high byte is a monitor-type code that software cannot change. The block latches this code from an input pin while reset is held. The low byte is a processor control byte that software can write, and two of its bits are also driven out as clock-select outputs. A mode input picks between strict alignment and relaxed alignment. In strict mode, multi-byte accesses at odd addresses raise an address error. In relaxed mode, those accesses are allowed.

The window offset sits in address bits 15:0. The window is selected when address bits 23:16 equal 0xFF.

Top module: `io_window_decoder`

## Requirements
- R1: An access with `addr[23:16]` different from 0xFF gets no response: `ack`, `berr` and `aerr` stay low, and the control byte does not change.
- R2: Every access inside the window raises exactly one of `ack`, `berr` or `aerr`. It does so for one cycle, in the cycle after the clock edge that samples `req`.
- R3: Size codes are 0 = byte, 1 = word, and 2 or 3 = long. A byte access to an unassigned offset gives `berr`. The void offsets 0x800A–0x800D, 0x8060–0x8063, 0x860E and 0x893B give `ack`, read as zero, and discard writes.
- R4: A word access gives `berr` only when both of the bytes it covers would give `berr` on their own.
- R5: A long access at offset a is judged as a word at a and a word at a+2. It gives `berr` when either word does so under R4.
- R6: With `align_strict` = 1, a word or long access at an odd address gives `aerr` and writes nothing. With `align_strict` = 0, the same access is handled by R4 and R5.
- R7: Offset 0x8006 reads the value that `mon_id` had during reset. Writes to it and later changes of the pin leave it unchanged.
- R8: Offset 0x8007 is the control byte. Only bits 0, 2 and 5 are stored, and the other bits read as zero. The byte is written only by an access that ends in `ack`.
- R9: `cpu_fast` follows control bit 0 and `blit_fast` follows control bit 2. Both change on the same edge that completes the write.
- R10: Read data is big-endian and right-justified: the lowest address goes into the most significant used byte. `rdata` is zero except in the response cycle of an acknowledged read.
- R11: After reset the control byte is zero, and all response outputs and clock-select outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the monitor code is latched while it is low |
| req | input | 1 | Access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 24 | Byte address; bits 23:16 select the window |
| size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| wdata | input | 32 | Write data, right-justified, big-endian |
| align_strict | input | 1 | 1 = odd multi-byte accesses raise an address error |
| mon_id | input | 8 | Static monitor-type code, sampled during reset |
| rdata | output | 32 | Read data, valid with `ack` |
| ack | output | 1 | Transfer acknowledge |
| berr | output | 1 | Bus-error response |
| aerr | output | 1 | Address-error response |
| cpu_fast | output | 1 | CPU clock select (1 = fast) |
| blit_fast | output | 1 | Blitter clock select (1 = fast) |

## Verification
Every response (`ack`, `berr`, `aerr`, `rdata`) is due in the cycle that follows the rising edge that sampled `req`. The clock-select outputs change on that same edge. The bench drives each access on a falling edge and lets the next rising edge capture it. It samples all outputs on the falling edge after that, so every check reads a settled value one register stage from its stimulus. Before the next access begins, a read of 0x8007 or the clock-select outputs show whether a write landed or was discarded.

// File: rtl/iod_pkg.sv
package iod_pkg;

   typedef enum logic [1:0] {
      BC_FAULT = 2'd0,
      BC_VOID  = 2'd1,
      BC_MON   = 2'd2,
      BC_CTRL  = 2'd3
   } byte_cls_e;

   localparam logic [15:0] CFG_MON_OFF  = 16'h8006;
   localparam logic [15:0] CFG_CTRL_OFF = 16'h8007;

   localparam logic [15:0] HOLE_A_LO = 16'h800A;
   localparam logic [15:0] HOLE_A_HI = 16'h800D;
   localparam logic [15:0] HOLE_B_LO = 16'h8060;
   localparam logic [15:0] HOLE_B_HI = 16'h8063;
   localparam logic [15:0] HOLE_C    = 16'h860E;
   localparam logic [15:0] HOLE_D    = 16'h893B;

   function automatic byte_cls_e classify(input logic [15:0] off);
      byte_cls_e c;
      if (off == CFG_MON_OFF)                          c = BC_MON;
      else if (off == CFG_CTRL_OFF)                    c = BC_CTRL;
      else if (off >= HOLE_A_LO && off <= HOLE_A_HI)   c = BC_VOID;
      else if (off >= HOLE_B_LO && off <= HOLE_B_HI)   c = BC_VOID;
      else if (off == HOLE_C || off == HOLE_D)         c = BC_VOID;
      else                                             c = BC_FAULT;
      return c;
   endfunction

   function automatic logic [2:0] size_bytes(input logic [1:0] sz);
      logic [2:0] n;
      case (sz)
         2'd0:    n = 3'd1;
         2'd1:    n = 3'd2;
         default: n = 3'd4;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/iod_lane_class.sv
module iod_lane_class
   import iod_pkg::*;
#(
   parameter int unsigned LANE = 0
)(
   input  logic [15:0] base_off,
   input  logic [2:0]  nbytes,
   output logic        active,
   output logic        fault,
   output logic        hit_mon,
   output logic        hit_ctrl
);
   logic [15:0] off;
   byte_cls_e   cls;

   assign off      = base_off + 16'(LANE);
   assign cls      = classify(off);
   assign active   = (32'(nbytes) > LANE);
   assign fault    = (cls == BC_FAULT);
   assign hit_mon  = (cls == BC_MON);
   assign hit_ctrl = (cls == BC_CTRL);
endmodule

// File: rtl/iod_fault_merge.sv
module iod_fault_merge #(
   parameter int unsigned LANES = 4
)(
   input  logic [LANES-1:0] lane_fault,
   input  logic [2:0]       nbytes,
   input  logic             odd,
   input  logic             strict,
   output logic             fault,
   output logic             misalign
);
   localparam int unsigned WORDS = LANES / 2;

   logic [WORDS-1:0] word_fault;

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         assign word_fault[w] = lane_fault[2*w] & lane_fault[2*w+1];
      end
   endgenerate

   always_comb begin
      case (nbytes)
         3'd1:    fault = lane_fault[0];
         3'd2:    fault = word_fault[0];
         default: fault = |word_fault;
      endcase
   end

   assign misalign = strict & odd & (nbytes != 3'd1);
endmodule

// File: rtl/iod_cfg_reg.sv
module iod_cfg_reg #(
   parameter logic [7:0] CTRL_MASK = 8'h25
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] mon_pin,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   output logic [7:0] mon_q,
   output logic [7:0] ctrl_q
);
   logic unused_wr;
   assign unused_wr = ^wr_byte;

   always_ff @(posedge clk) begin
      if (!rst_n) mon_q <= mon_pin;
   end

   generate
      for (genvar b = 0; b < 8; b++) begin : g_bit
         if (CTRL_MASK[b]) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     ctrl_q[b] <= 1'b0;
               else if (wr_en) ctrl_q[b] <= wr_byte[b];
            end
         end else begin : g_tie
            assign ctrl_q[b] = 1'b0;
         end
      end
   endgenerate

   // R7: monitor code never moves once reset is released
   p_mon_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mon_q));

   // R8: control byte only changes through a write strobe
   p_ctrl_only_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) && $past(rst_n) |-> $stable(ctrl_q));
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
   import iod_pkg::*;
#(
   parameter int unsigned ADDR_W    = 24,
   parameter int unsigned WIN_HI    = 'hFF,
   parameter logic [7:0]  CTRL_MASK = 8'h25,
   parameter int unsigned LANES     = 4
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic                we,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [1:0]          size,
   input  logic [8*LANES-1:0]  wdata,
   input  logic                align_strict,
   input  logic [7:0]          mon_id,
   output logic [8*LANES-1:0]  rdata,
   output logic                ack,
   output logic                berr,
   output logic                aerr,
   output logic                cpu_fast,
   output logic                blit_fast
);
   localparam int unsigned HI_W   = ADDR_W - 16;
   localparam int unsigned DATA_W = 8 * LANES;

   generate
      if (ADDR_W < 17) begin : g_bad_addr_w
         initial $fatal(1, "ADDR_W must exceed 16");
      end
      if (LANES != 4) begin : g_bad_lanes
         initial $fatal(1, "LANES must be 4 (byte, word, long)");
      end
      if (WIN_HI >= (1 << HI_W)) begin : g_bad_win
         initial $fatal(1, "WIN_HI does not fit above bit 15");
      end
   endgenerate

   logic              in_win;
   logic [2:0]        nb;
   logic [LANES-1:0]  lane_act, lane_flt, lane_mon, lane_ctl;
   logic              fault, misalign, sel;
   logic [7:0]        mon_q, ctrl_q, ctrl_wbyte, lane_val;
   logic [DATA_W-1:0] rd_next;
   logic              ctrl_wr;
   int                sh;

   assign in_win = (addr[ADDR_W-1:16] == HI_W'(WIN_HI));
   assign nb     = size_bytes(size);
   assign sel    = req & in_win;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         iod_lane_class #(.LANE(i)) u_lane (
            .base_off (addr[15:0]),
            .nbytes   (nb),
            .active   (lane_act[i]),
            .fault    (lane_flt[i]),
            .hit_mon  (lane_mon[i]),
            .hit_ctrl (lane_ctl[i])
         );
      end
   endgenerate

   iod_fault_merge #(.LANES(LANES)) u_merge (
      .lane_fault (lane_flt),
      .nbytes     (nb),
      .odd        (addr[0]),
      .strict     (align_strict),
      .fault      (fault),
      .misalign   (misalign)
   );

   always_comb begin
      rd_next    = '0;
      ctrl_wbyte = '0;
      sh         = 0;
      lane_val   = '0;
      for (int i = 0; i < LANES; i++) begin
         if (lane_act[i]) begin
            sh       = 8 * (int'(nb) - 1 - i);
            lane_val = lane_mon[i] ? mon_q : (lane_ctl[i] ? ctrl_q : 8'h00);
            rd_next  = rd_next | (DATA_W'(lane_val) << sh);
            if (lane_ctl[i]) ctrl_wbyte = 8'(wdata >> sh);
         end
      end
   end

   assign ctrl_wr = sel & we & ~fault & ~misalign & |(lane_act & lane_ctl);

   iod_cfg_reg #(.CTRL_MASK(CTRL_MASK)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .mon_pin (mon_id),
      .wr_en   (ctrl_wr),
      .wr_byte (ctrl_wbyte),
      .mon_q   (mon_q),
      .ctrl_q  (ctrl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack   <= 1'b0;
         berr  <= 1'b0;
         aerr  <= 1'b0;
         rdata <= '0;
      end else begin
         ack   <= sel & ~misalign & ~fault;
         berr  <= sel & ~misalign & fault;
         aerr  <= sel & misalign;
         rdata <= (sel & ~misalign & ~fault & ~we) ? rd_next : '0;
      end
   end

   assign cpu_fast  = ctrl_q[0];
   assign blit_fast = ctrl_q[2];

   // R2: at most one response flag per cycle
   p_one_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack, berr, aerr}));

   // R1: a response needs an in-window request one cycle earlier
   p_resp_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ack || berr || aerr) |-> $past(req && in_win));

   // R6: address error only for strict mode at an odd address
   p_aerr_strict_r6: assert property (@(posedge clk) disable iff (!rst_n)
      aerr |-> $past(align_strict && addr[0]));

   // R8: a faulted or misaligned access leaves the control byte alone
   p_no_write_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && (fault || misalign)) |=> $stable(ctrl_q));

   // R10: read data is quiet outside an acknowledge
   p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |-> (rdata == '0));
endmodule

// File: tb/test_io_window_decoder.sv
`timescale 1ns/1ps
module test_io_window_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [23:0] addr = '0;
   logic [1:0]  size = '0;
   logic [31:0] wdata = '0;
   logic        align_strict = 1'b0;
   logic [7:0]  mon_id = 8'hA5;
   logic [31:0] rdata;
   logic        ack, berr, aerr, cpu_fast, blit_fast;

   int nchk = 0, nerr = 0;
   logic [7:0]  ctrl_m = 8'h00;
   logic [7:0]  mon_m  = 8'hA5;
   logic [31:0] last_rd;
   logic [2:0]  last_flags;

   always #2.5 clk = ~clk;

   io_window_decoder i_io_window_decoder (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
      .wdata(wdata), .align_strict(align_strict), .mon_id(mon_id),
      .rdata(rdata), .ack(ack), .berr(berr), .aerr(aerr),
      .cpu_fast(cpu_fast), .blit_fast(blit_fast));

   function automatic int bcls(input logic [15:0] o);
      if (o == 16'h8006) return 2;
      if (o == 16'h8007) return 3;
      if (o >= 16'h800A && o <= 16'h800D) return 1;
      if (o >= 16'h8060 && o <= 16'h8063) return 1;
      if (o == 16'h860E || o == 16'h893B) return 1;
      return 0;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one access: drive on falling edge, sample on the next falling edge
   task automatic do_acc(input logic w, input logic [7:0] hi, input logic [15:0] off,
                         input logic [1:0] sz, input logic [31:0] wd);
      int nb;
      logic inw, ae, fe, ok;
      logic [3:0] fl;
      logic [31:0] rexp;
      logic [7:0] nctrl, v;
      string tag;
      nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      inw = (hi == 8'hFF);
      for (int i = 0; i < 4; i++) fl[i] = (bcls(off + 16'(i)) == 0);
      ae = inw && align_strict && off[0] && (nb > 1);
      if (nb == 1)      fe = fl[0];
      else if (nb == 2) fe = fl[0] & fl[1];
      else              fe = (fl[0] & fl[1]) | (fl[2] & fl[3]);
      fe = fe && inw && !ae;
      ok = inw && !ae && !fe;
      rexp  = '0;
      nctrl = ctrl_m;
      for (int i = 0; i < nb; i++) begin
         case (bcls(off + 16'(i)))
            2:       v = mon_m;
            3:       v = ctrl_m;
            default: v = 8'h00;
         endcase
         rexp = rexp | (32'(v) << (8 * (nb - 1 - i)));
         if (bcls(off + 16'(i)) == 3) nctrl = 8'(wd >> (8 * (nb - 1 - i))) & 8'h25;
      end
      if (!(ok && !w)) rexp = '0;
      if (!inw)         tag = "R1";
      else if (ae)      tag = "R6";
      else if (nb == 1) tag = "R3";
      else if (nb == 2) tag = "R4";
      else              tag = "R5";
      req = 1'b1; we = w; addr = {hi, off}; size = sz; wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      if (ok && w) ctrl_m = nctrl;
      last_rd    = rdata;
      last_flags = {ack, berr, aerr};
      check(tag, {29'd0, ack, berr, aerr}, {29'd0, ok, fe, ae});
      if (inw) check("R2", 32'($countones({ack, berr, aerr})), 32'd1);
      check("R10", rdata, rexp);
      check("R9", {30'd0, blit_fast, cpu_fast}, {30'd0, ctrl_m[2], ctrl_m[0]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      mon_id = 8'h3C;   // later pin changes must be ignored
      @(negedge clk);
      // R11 reset state
      check("R11", {27'd0, ack, berr, aerr, cpu_fast, blit_fast}, 32'd0);
      check("R11", rdata, 32'd0);

      // R7 monitor code latched during reset
      do_acc(1'b0, 8'hFF, 16'h8006, 2'd0, 32'd0);
      check("R7", last_rd, 32'h0000_00A5);
      do_acc(1'b1, 8'hFF, 16'h8006, 2'd0, 32'h0000_0011);
      do_acc(1'b0, 8'hFF, 16'h8006, 2'd0, 32'd0);
      check("R7", last_rd, 32'h0000_00A5);

      // R8 control byte masking
      do_acc(1'b1, 8'hFF, 16'h8007, 2'd0, 32'h0000_00FF);
      do_acc(1'b0, 8'hFF, 16'h8007, 2'd0, 32'd0);
      check("R8", last_rd, 32'h0000_0025);
      check("R9", {30'd0, blit_fast, cpu_fast}, 32'd3);
      // word write to 0x8006 updates control, not monitor
      do_acc(1'b1, 8'hFF, 16'h8006, 2'd1, 32'h0000_1234);
      do_acc(1'b0, 8'hFF, 16'h8006, 2'd1, 32'd0);
      check("R8", last_rd, 32'h0000_A524);
      // long at 0x8004: first word faults -> berr, no write
      do_acc(1'b1, 8'hFF, 16'h8004, 2'd2, 32'hFFFF_FFFF);
      check("R5", {29'd0, last_flags}, 32'd2);
      // odd word relaxed at 0x8007 writes control from high byte
      align_strict = 1'b0;
      do_acc(1'b1, 8'hFF, 16'h8007, 2'd1, 32'h0000_0104);
      check("R6", {30'd0, blit_fast, cpu_fast}, 32'd1);
      align_strict = 1'b1;
      do_acc(1'b1, 8'hFF, 16'h8007, 2'd1, 32'h0000_0400);
      check("R6", {29'd0, last_flags}, 32'd1);
      check("R6", {30'd0, blit_fast, cpu_fast}, 32'd1);

      // R1 outside window
      do_acc(1'b1, 8'hFE, 16'h8007, 2'd0, 32'h0000_0004);
      do_acc(1'b0, 8'hFF, 16'h8007, 2'd0, 32'd0);
      check("R1", last_rd, 32'h0000_0001);

      // near-exhaustive read sweep, both alignment modes
      for (int m = 0; m < 2; m++) begin
         align_strict = m[0];
         for (int o = 16'h7FFC; o <= 16'h8070; o++)
            for (int s = 0; s < 3; s++) do_acc(1'b0, 8'hFF, 16'(o), 2'(s), 32'd0);
         for (int o = 16'h8600; o <= 16'h8612; o++)
            for (int s = 0; s < 3; s++) do_acc(1'b0, 8'hFF, 16'(o), 2'(s), 32'd0);
         for (int o = 16'h8930; o <= 16'h8942; o++)
            for (int s = 0; s < 3; s++) do_acc(1'b0, 8'hFF, 16'(o), 2'(s), 32'd0);
      end

      // write sweep with read-back of the control byte
      for (int m = 0; m < 2; m++) begin
         align_strict = m[0];
         for (int o = 16'h7FF8; o <= 16'h8070; o++)
            for (int s = 0; s < 3; s++) begin
               do_acc(1'b1, 8'hFF, 16'(o), 2'(s), {16'(o), ~16'(o)} ^ 32'(s * 32'h0505_0505));
               do_acc(1'b0, 8'hFF, 16'h8007, 2'd0, 32'd0);
            end
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule